// File: doc/BRIEF.md
# Three-Level Nested Interrupt Priority Controller

This block collects a wide set of interrupt request sources, folds them into a small fixed set of vector slots, and presents a single registered request to the CPU. It also presents the entry address of the chosen vector and the priority level that servicing it would enter. Each slot carries a two-bit priority field with three active levels. The controller keeps the level of the routine now running and a short stack of interrupted levels, so handlers can nest.

A request is offered only when its level is strictly above the current level. The CPU answers an offered request with an acknowledge strobe, which raises the current level to the offered one. It ends a handler with a return strobe, which restores the level that was interrupted. Source flags are never cleared here; software clears them in the peripherals.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_o is 0, cur_lvl_o is 0 (idle, below the lowest active level) and the level stack is empty.
- R2: Source s belongs to vector s mod N_VEC. A vector requests when any of its sources has both its pend and enable bit at 1. A vector whose level field (bits 2v+1:2v of vec_lvl_i) is 0 never requests.
- R3: A vector is offered only if its level is strictly greater than cur_lvl_o. A request at the current level or below stays unoffered.
- R4: Among eligible vectors, the one with the highest level (3 above 2 above 1) is offered.
- R5: Among eligible vectors at the same highest level, the lowest vector index is offered.
- R6: When offering vector v, vec_addr_o = 0x0003 + 8*v and lvl_o = that vector's level.
- R7: The offer is registered, appearing one clock after the inputs. Without acknowledge it stays unchanged, unless an eligible vector of strictly higher level appears. A new same-level request at a lower index does not replace it.
- R8: An acknowledge while irq_o = 1 pushes cur_lvl_o, sets cur_lvl_o to lvl_o and drops irq_o on the next clock. An acknowledge while irq_o = 0 has no effect. An acknowledge taken together with a return makes the return ignored.
- R9: A return with a non-empty stack restores the most recently pushed level. A return with an empty stack leaves cur_lvl_o at 0.
- R10: Three nested acknowledges at levels 1, 2, 3 unwind through returns as 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pend_i | input | N_SRC | Per-source pending flags |
| src_en_i | input | N_SRC | Per-source enables |
| vec_lvl_i | input | 2*N_VEC | Per-vector level, 0 = masked, 1..3 active |
| ack_i | input | 1 | CPU acknowledge strobe |
| reti_i | input | 1 | CPU return-from-interrupt strobe |
| irq_o | output | 1 | Registered interrupt request |
| vec_addr_o | output | ADDR_W | Entry address of the offered vector |
| lvl_o | output | 2 | Level entered if the offer is acknowledged |
| cur_lvl_o | output | 2 | Level currently being serviced |

## Verification
The hardest situation to reach from the ports is a deep nest. A lower-level source must stay pending while a higher one preempts it, and each return must uncover the blocked request at the right moment. The bench acknowledges in turn at levels 1, 2 and 3. It then unwinds with returns and checks the restored level after each one, plus one extra return on an empty stack. Replacement against hold is reached by adding a same-level, lower-index request and then a higher-level one on top of an offer that has not been acknowledged. A few hundred resets with pseudo-random flag, enable and level patterns sweep the priority and tie rules against an arithmetic model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/vic_gather.sv
module vic_gather #(
  parameter int N_SRC = 36,
  parameter int N_VEC = 10
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_VEC-1:0] vec_req_o
);
  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    logic [N_SRC-1:0] member;
    always_comb begin
      for (int s = 0; s < N_SRC; s++) member[s] = ((s % N_VEC) == v);
    end
    assign vec_req_o[v] = |(pend_i & en_i & member);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N_VEC = 10,
  localparam int IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic [N_VEC-1:0]       vec_req_i,
  input  logic [LVL_W*N_VEC-1:0] vec_lvl_i,
  input  lvl_t                   cur_lvl_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o,
  output lvl_t                   lvl_o
);
  logic [N_VEC-1:0] elig;

  for (genvar v = 0; v < N_VEC; v++) begin : g_elig
    assign elig[v] = vec_req_i[v] && (vec_lvl_i[v*LVL_W +: LVL_W] > cur_lvl_i);
  end

  // descending scan, >= lets the lower index win a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_IDLE;
    for (int v = N_VEC - 1; v >= 0; v--) begin
      if (elig[v] && (vec_lvl_i[v*LVL_W +: LVL_W] >= lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(v);
        lvl_o   = vec_lvl_i[v*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
  import vic_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t push_val_i,
  output lvl_t top_o,
  output logic empty_o
);
  lvl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? LVL_IDLE : mem[PTR_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= LVL_IDLE;
    end else if (push_i) begin
      mem[PTR_W'(cnt_q)] <= push_val_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int          N_SRC     = 36,
  parameter int          N_VEC     = 10,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] VEC_BASE  = 16'h0003,
  parameter int          VEC_STEP  = 8,
  parameter int          NEST_DEPTH = 3,
  localparam int         IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_pend_i,
  input  logic [N_SRC-1:0]       src_en_i,
  input  logic [LVL_W*N_VEC-1:0] vec_lvl_i,
  input  logic                   ack_i,
  input  logic                   reti_i,
  output logic                   irq_o,
  output logic [ADDR_W-1:0]      vec_addr_o,
  output logic [LVL_W-1:0]       lvl_o,
  output logic [LVL_W-1:0]       cur_lvl_o
);
  logic [N_VEC-1:0] vec_req;
  logic             cand_valid;
  logic [IDX_W-1:0] cand_idx;
  lvl_t             cand_lvl;
  lvl_t             stk_top;
  logic             stk_empty;
  logic             take, ret;

  logic             irq_q;
  logic [IDX_W-1:0] idx_q;
  lvl_t             lvl_q, cur_q;

  vic_gather #(.N_SRC(N_SRC), .N_VEC(N_VEC)) u_gather (
    .pend_i(src_pend_i), .en_i(src_en_i), .vec_req_o(vec_req)
  );

  vic_arbiter #(.N_VEC(N_VEC)) u_arb (
    .vec_req_i(vec_req), .vec_lvl_i(vec_lvl_i), .cur_lvl_i(cur_q),
    .valid_o(cand_valid), .idx_o(cand_idx), .lvl_o(cand_lvl)
  );

  assign take = ack_i && irq_q;
  assign ret  = reti_i && !take && !stk_empty;

  vic_level_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(take), .pop_i(ret),
    .push_val_i(cur_q), .top_o(stk_top), .empty_o(stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LVL_IDLE;
    end else if (take) begin
      cur_q <= lvl_q;
    end else if (ret) begin
      cur_q <= stk_top;
    end
  end

  // hold the offer; only a strictly higher level preempts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= LVL_IDLE;
    end else if (take) begin
      irq_q <= 1'b0;
    end else if (!irq_q || (cand_valid && (cand_lvl > lvl_q))) begin
      irq_q <= cand_valid;
      idx_q <= cand_idx;
      lvl_q <= cand_lvl;
    end
  end

  assign irq_o      = irq_q;
  assign lvl_o      = lvl_q;
  assign cur_lvl_o  = cur_q;
  assign vec_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q) * ADDR_W'(VEC_STEP);

  a_r3_offer_above_cur: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_o > cur_lvl_o));
  a_r6_addr_on_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (((vec_addr_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == '0));
  a_r7_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && (lvl_o >= $past(lvl_o))));
  a_r8_ack_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!irq_o && (cur_lvl_o == $past(lvl_o))));
  a_r9_return_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(ack_i && irq_o) && (cur_lvl_o != LVL_IDLE)) |=> (cur_lvl_o < $past(cur_lvl_o)));
  a_r8_level_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && irq_o) && !reti_i) |=> $stable(cur_lvl_o));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  localparam int NS = 36;
  localparam int NV = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] pend = '0;
  logic [NS-1:0] en = '0;
  logic [1:0]    lv [NV];
  logic [2*NV-1:0] vec_lvl;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq;
  logic [15:0]   addr;
  logic [1:0]    lvl, cur;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #2 clk_i = ~clk_i;

  always_comb begin
    for (int v = 0; v < NV; v++) vec_lvl[v*2 +: 2] = lv[v];
  end

  irq_vector_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_pend_i(pend), .src_en_i(en),
    .vec_lvl_i(vec_lvl), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_addr_o(addr), .lvl_o(lvl), .cur_lvl_o(cur)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pend = '0; en = '0; ack = 1'b0; reti = 1'b0;
    for (int v = 0; v < NV; v++) lv[v] = 2'd0;
    step();
    rst_ni = 1'b1;
    step();
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // arithmetic reference: best = highest level, then lowest index
  task automatic model(input int c, output bit ok, output int bidx, output int blvl);
    ok = 0; bidx = 0; blvl = 0;
    for (int v = 0; v < NV; v++) begin
      bit r = 0;
      for (int s = v; s < NS; s += NV) r |= pend[s] & en[s];
      if (r && int'(lv[v]) > c && int'(lv[v]) > blvl) begin
        ok = 1; bidx = v; blvl = int'(lv[v]);
      end
    end
  endtask

  task automatic ack_pulse();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic reti_pulse();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ok; int ei, el;
    for (int v = 0; v < NV; v++) lv[v] = 2'd0;
    step();
    check("R1 irq after reset", int'(irq), 0);
    check("R1 cur after reset", int'(cur), 0);
    do_reset();
    check("R1 irq idle", int'(irq), 0);

    // R2/R6: every source alone, enabled and then disabled
    for (int s = 0; s < NS; s++) begin
      do_reset();
      for (int v = 0; v < NV; v++) lv[v] = 2'((v % 3) + 1);
      pend[s] = 1'b1;
      step();
      check("R2 disabled source idle", int'(irq), 0);
      en[s] = 1'b1;
      step();
      check("R2 single source irq", int'(irq), 1);
      check("R6 single source addr", int'(addr), 3 + 8 * (s % NV));
      check("R6 single source lvl", int'(lvl), (s % NV) % 3 + 1);
    end

    // R2: level field 0 masks vector
    do_reset();
    pend = '1; en = '1;
    step();
    check("R2 all masked", int'(irq), 0);

    // R3/R4/R5 sweep
    for (int k = 0; k < 300; k++) begin
      do_reset();
      pend = {rnd(), rnd()};
      en   = {rnd(), rnd()};
      for (int v = 0; v < NV; v++) lv[v] = 2'(rnd() % 4);
      step();
      model(0, ok, ei, el);
      check("R4 R5 sweep irq", int'(irq), int'(ok));
      if (ok) begin
        check("R5 sweep addr", int'(addr), 3 + 8 * ei);
        check("R4 sweep lvl", int'(lvl), el);
      end
    end

    // R7 hold and preempt
    do_reset();
    lv[5] = 2'd1; lv[2] = 2'd1; lv[7] = 2'd3;
    en[5] = 1'b1; en[2] = 1'b1; en[7] = 1'b1;
    pend[5] = 1'b1;
    step();
    check("R7 first offer addr", int'(addr), 3 + 40);
    pend[2] = 1'b1;
    step(); step();
    check("R7 same level no replace", int'(addr), 3 + 40);
    check("R7 still requesting", int'(irq), 1);
    pend[7] = 1'b1;
    step();
    check("R7 higher replaces addr", int'(addr), 3 + 56);
    check("R7 higher replaces lvl", int'(lvl), 3);

    // R8 ack, R3 blocking
    ack_pulse();
    check("R8 irq drops", int'(irq), 0);
    check("R8 cur enters", int'(cur), 3);
    step(); step();
    check("R3 lower blocked", int'(irq), 0);
    ack_pulse();
    check("R8 ack ignored when idle", int'(cur), 3);

    // R9 return, blocked request reappears
    pend[7] = 1'b0;
    reti_pulse();
    check("R9 return restores", int'(cur), 0);
    step();
    check("R3 request after return", int'(irq), 1);
    check("R5 lowest index after return", int'(addr), 3 + 16);

    // R10 nesting
    do_reset();
    lv[4] = 2'd1; lv[8] = 2'd2; lv[1] = 2'd3;
    en[4] = 1'b1; en[8] = 1'b1; en[1] = 1'b1;
    pend[4] = 1'b1;
    step();
    ack_pulse();
    check("R10 enter 1", int'(cur), 1);
    pend[8] = 1'b1;
    step(); step();
    check("R10 level 2 offered", int'(lvl), 2);
    ack_pulse();
    check("R10 enter 2", int'(cur), 2);
    pend[1] = 1'b1;
    step(); step();
    check("R10 level 3 addr", int'(addr), 3 + 8);
    // R8: ack with reti together, reti ignored
    ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
    check("R8 ack beats return", int'(cur), 3);
    pend = '0;
    reti_pulse();
    check("R10 unwind to 2", int'(cur), 2);
    reti_pulse();
    check("R10 unwind to 1", int'(cur), 1);
    reti_pulse();
    check("R10 unwind to 0", int'(cur), 0);
    reti_pulse();
    check("R9 empty return", int'(cur), 0);
    check("R9 no request", int'(irq), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule